// File: doc/BRIEF.md
# Transceiver Rate-Change Reset Sequencer

This block steers one serial transceiver channel through a data-rate change. When a request arrives, it writes a new 3-bit mode value to an external dynamic reconfiguration controller and then pulses that controller's write-all strobe. It also drives the transmit digital reset, the receive analog reset and the receive digital reset of the channel. It holds all three resets while the controller reports busy and waits for the controller's done pulse. It then releases the resets one after another in a fixed order.

The receive analog reset is released first, directly after done. The transmit digital reset follows after a fixed delay counted in parallel clock cycles. The receive digital reset is released last: the receiver CDR must first report frequency lock for an unbroken interval of several microseconds. A one-cycle completion flag marks the end of the sequence.

Out of reset the block holds all three resets asserted until the first sequence completes. The reconfiguration controller and the CDR are outside this block.

Top module: `xrs_rate_seq`

## Requirements
- R1: From reset until the first completed sequence, all three reset outputs are high and `seq_done_o` is low.
- R2: A request accepted when no sequence is running is followed, one cycle later, by a single-cycle `cfg_wr_o` pulse with `cfg_mode_o` equal to the 3-bit mode captured with the request. In the cycle after that pulse, `write_all_o` is high for exactly one cycle.
- R3: All three reset outputs are high from the configuration write cycle until the controller's done is seen.
- R4: After the strobe the block waits for `busy_i` and then for `done_i`. No reset is released before done. The receive analog reset drops in the cycle after `done_i` is sampled high, while both digital resets stay high.
- R5: The transmit digital reset stays high for exactly TX_DLY clock cycles (default 5) after the receive analog reset has dropped.
- R6: Once the transmit digital reset has dropped, the receive digital reset drops after `freqlock_i` has been high for LOCK_CYC = CLK_MHZ × LOCK_US consecutive cycles (default 100 × 4 = 400).
- R7: Frequency lock seen before the transmit digital reset is released earns no credit toward the R6 interval.
- R8: A low cycle on `freqlock_i` during the R6 interval restarts the count, and the receive digital reset stays high. If lock never arrives, the receive digital reset stays high indefinitely.
- R9: `seq_done_o` is high for exactly one cycle, in the same cycle in which the receive digital reset first drops. All three resets are low at that point.
- R10: A request raised while a sequence is running is ignored: no configuration write occurs, `cfg_mode_o` is unchanged, and after completion the resets stay low with no new write until a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Rate-change request |
| mode_i | input | 3 | Requested mode, captured with an accepted request |
| cfg_mode_o | output | 3 | Mode value written to the reconfiguration controller |
| cfg_wr_o | output | 1 | Configuration register write strobe |
| write_all_o | output | 1 | Starts the controller's reconfiguration |
| busy_i | input | 1 | Controller is running |
| done_i | input | 1 | Controller finished the channel reconfiguration |
| freqlock_i | input | 1 | Receiver CDR frequency lock |
| tx_dig_rst_o | output | 1 | Transmit digital reset, active high |
| rx_ana_rst_o | output | 1 | Receive analog reset, active high |
| rx_dig_rst_o | output | 1 | Receive digital reset, active high |
| seq_done_o | output | 1 | One-cycle completion flag |

## Verification
Lock is driven high before the analog reset is released. A design that counts it early would free the receive digital reset too soon, and the bench measures the exact number of cycles from the transmit release to the receive digital release. A lock drop halfway through the window would show up as an early release in a design that pauses its counter instead of clearing it. A stretch with no lock at all would expose a design that times out and releases anyway. Requests raised while the block waits for done would appear as a second configuration write or a changed mode in a design that accepts them. The bench also checks the exact five-cycle transmit delay and the single-cycle strobe and done pulses for every mode value.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [3:0] {
    ST_PWR   = 4'd0,
    ST_IDLE  = 4'd1,
    ST_LOAD  = 4'd2,
    ST_KICK  = 4'd3,
    ST_BUSYW = 4'd4,
    ST_DONEW = 4'd5,
    ST_TXW   = 4'd6,
    ST_LOCKW = 4'd7,
    ST_FIN   = 4'd8
  } xrs_state_e;

  typedef struct packed {
    logic tx_dig;
    logic rx_ana;
    logic rx_dig;
  } xrs_rst_t;

  function automatic int us_to_cycles(input int clk_mhz, input int usec);
    return clk_mhz * usec;
  endfunction

  function automatic xrs_rst_t rst_for_state(input xrs_state_e st);
    xrs_rst_t r;
    case (st)
      ST_IDLE, ST_FIN: r = '{tx_dig: 1'b0, rx_ana: 1'b0, rx_dig: 1'b0};
      ST_TXW:          r = '{tx_dig: 1'b1, rx_ana: 1'b0, rx_dig: 1'b1};
      ST_LOCKW:        r = '{tx_dig: 1'b0, rx_ana: 1'b0, rx_dig: 1'b1};
      default:         r = '{tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xrs_timer.sv
module xrs_timer #(
  parameter int N = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic expire_o
);
  localparam int W = $clog2(N + 1);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/xrs_fsm.sv
module xrs_fsm
  import xrs_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              freqlock_i,
  input  logic              tx_expire_i,
  input  logic              lock_expire_i,
  output logic              tx_win_en_o,
  output logic              lock_en_o,
  output logic [MODE_W-1:0] cfg_mode_o,
  output logic              cfg_wr_o,
  output logic              write_all_o,
  output xrs_rst_t          rst_o,
  output logic              seq_done_o
);
  xrs_state_e st_q, st_d;
  logic [MODE_W-1:0] mode_q;
  logic accept;

  assign accept = req_i && (st_q == ST_PWR || st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_PWR, ST_IDLE: if (accept) st_d = ST_LOAD;
      ST_LOAD:         st_d = ST_KICK;
      ST_KICK:         st_d = ST_BUSYW;
      ST_BUSYW:        if (busy_i) st_d = ST_DONEW;
      ST_DONEW:        if (done_i) st_d = ST_TXW;
      ST_TXW:          if (tx_expire_i) st_d = ST_LOCKW;
      ST_LOCKW:        if (lock_expire_i) st_d = ST_FIN;
      ST_FIN:          st_d = ST_IDLE;
      default:         st_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_PWR;
      mode_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) mode_q <= mode_i;
    end
  end

  assign tx_win_en_o = (st_q == ST_TXW);
  assign lock_en_o   = (st_q == ST_LOCKW) && freqlock_i;
  assign cfg_mode_o  = mode_q;
  assign cfg_wr_o    = (st_q == ST_LOAD);
  assign write_all_o = (st_q == ST_KICK);
  assign rst_o       = rst_for_state(st_q);
  assign seq_done_o  = (st_q == ST_FIN);
endmodule

// File: rtl/xrs_rate_seq.sv
module xrs_rate_seq
  import xrs_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int LOCK_US = 4,
  parameter int TX_DLY  = 5,
  parameter int MODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] cfg_mode_o,
  output logic              cfg_wr_o,
  output logic              write_all_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              freqlock_i,
  output logic              tx_dig_rst_o,
  output logic              rx_ana_rst_o,
  output logic              rx_dig_rst_o,
  output logic              seq_done_o
);
  localparam int LOCK_CYC = us_to_cycles(CLK_MHZ, LOCK_US);

  logic     tx_win_en, lock_en, tx_expire, lock_expire;
  xrs_rst_t rst_vec;

  xrs_fsm #(.MODE_W(MODE_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .mode_i       (mode_i),
    .busy_i       (busy_i),
    .done_i       (done_i),
    .freqlock_i   (freqlock_i),
    .tx_expire_i  (tx_expire),
    .lock_expire_i(lock_expire),
    .tx_win_en_o  (tx_win_en),
    .lock_en_o    (lock_en),
    .cfg_mode_o   (cfg_mode_o),
    .cfg_wr_o     (cfg_wr_o),
    .write_all_o  (write_all_o),
    .rst_o        (rst_vec),
    .seq_done_o   (seq_done_o)
  );

  xrs_timer #(.N(TX_DLY)) u_tx_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (tx_win_en),
    .expire_o(tx_expire)
  );

  xrs_timer #(.N(LOCK_CYC)) u_lock_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (lock_en),
    .expire_o(lock_expire)
  );

  assign tx_dig_rst_o = rst_vec.tx_dig;
  assign rx_ana_rst_o = rst_vec.rx_ana;
  assign rx_dig_rst_o = rst_vec.rx_dig;
endmodule

// File: rtl/xrs_rate_seq_chk.sv
module xrs_rate_seq_chk #(
  parameter int CLK_MHZ = 100,
  parameter int LOCK_US = 4,
  parameter int TX_DLY  = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr_o,
  input logic write_all_o,
  input logic done_i,
  input logic freqlock_i,
  input logic tx_dig_rst_o,
  input logic rx_ana_rst_o,
  input logic rx_dig_rst_o,
  input logic seq_done_o
);
  localparam int LOCK_CYC = CLK_MHZ * LOCK_US;

  logic [31:0] tx_cnt, lk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt <= '0;
      lk_cnt <= '0;
    end else begin
      tx_cnt <= (tx_dig_rst_o && !rx_ana_rst_o) ? tx_cnt + 1 : '0;
      lk_cnt <= (freqlock_i && !tx_dig_rst_o && rx_dig_rst_o) ? lk_cnt + 1 : '0;
    end
  end

  a_r2_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |=> write_all_o);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    write_all_o |=> !write_all_o);
  a_r3_resets_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o || write_all_o) |-> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o));
  a_r4_ana_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ana_rst_o) |-> ($past(done_i) && tx_dig_rst_o && rx_dig_rst_o));
  a_r5_tx_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_dig_rst_o) |-> (tx_cnt == 32'(TX_DLY) && !rx_ana_rst_o));
  a_r6_lock_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_dig_rst_o) |-> (lk_cnt == 32'(LOCK_CYC) && $past(freqlock_i)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |=> !seq_done_o);
  a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (!tx_dig_rst_o && !rx_ana_rst_o && !rx_dig_rst_o && $fell(rx_dig_rst_o)));
endmodule

bind xrs_rate_seq xrs_rate_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US), .TX_DLY(TX_DLY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_o    (cfg_wr_o),
  .write_all_o (write_all_o),
  .done_i      (done_i),
  .freqlock_i  (freqlock_i),
  .tx_dig_rst_o(tx_dig_rst_o),
  .rx_ana_rst_o(rx_ana_rst_o),
  .rx_dig_rst_o(rx_dig_rst_o),
  .seq_done_o  (seq_done_o)
);

// File: tb/sim_xrs_rate_seq.sv
module sim_xrs_rate_seq;
  localparam int CLK_MHZ = 10;
  localparam int LOCK_US = 4;
  localparam int TX_DLY  = 5;
  localparam int L_EXP   = (LOCK_US * 1000) / (1000 / CLK_MHZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] mode = '0;
  logic busy = 1'b0, done = 1'b0, lock = 1'b0;
  logic [2:0] cfg_mode;
  logic cfg_wr, wr_all, tx_r, ana_r, rxd_r, sdone;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  xrs_rate_seq #(.CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US), .TX_DLY(TX_DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
    .cfg_mode_o(cfg_mode), .cfg_wr_o(cfg_wr), .write_all_o(wr_all),
    .busy_i(busy), .done_i(done), .freqlock_i(lock),
    .tx_dig_rst_o(tx_r), .rx_ana_rst_o(ana_r), .rx_dig_rst_o(rxd_r),
    .seq_done_o(sdone)
  );

  task automatic check(input string req_tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int rsts();
    return {29'd0, tx_r, ana_r, rxd_r};
  endfunction

  task automatic run_seq(input int m, input int bd, input int dd, input int pat);
    int n;
    @(negedge clk); req = 1'b1; mode = 3'(m);
    @(negedge clk); req = 1'b0;
    check("R2 cfg_wr", int'(cfg_wr), 1);
    check("R2 cfg_mode", int'(cfg_mode), m);
    check("R2 no early strobe", int'(wr_all), 0);
    check("R3 resets at write", rsts(), 7);
    @(negedge clk);
    check("R2 strobe", int'(wr_all), 1);
    check("R2 write single", int'(cfg_wr), 0);
    if (pat == 0) lock = 1'b1;
    repeat (bd) @(negedge clk);
    busy = 1'b1;
    @(negedge clk);
    check("R2 strobe single", int'(wr_all), 0);
    req = 1'b1; mode = 3'(m) ^ 3'd7;
    @(negedge clk); req = 1'b0;
    check("R10 no rewrite", int'(cfg_wr), 0);
    check("R10 mode kept", int'(cfg_mode), m);
    repeat (dd) @(negedge clk);
    check("R4 held before done", rsts(), 7);
    done = 1'b1; busy = 1'b0;
    @(negedge clk); done = 1'b0;
    check("R4 analog release", rsts(), 5);
    n = 0;
    while (tx_r && n < 100) begin n++; @(negedge clk); end
    check("R5 tx delay", n, TX_DLY);
    check("R5 rxd still held", int'(rxd_r), 1);
    if (pat == 1) begin
      repeat (2 * L_EXP) @(negedge clk);
      check("R8 no lock holds rxd", int'(rxd_r), 1);
      lock = 1'b1;
    end else if (pat == 2) begin
      lock = 1'b1;
      repeat (L_EXP / 2) @(negedge clk);
      lock = 1'b0;
      @(negedge clk);
      check("R8 drop holds rxd", int'(rxd_r), 1);
      lock = 1'b1;
    end
    n = 0;
    while (rxd_r && n < 10 * L_EXP) begin n++; @(negedge clk); end
    check(pat == 0 ? "R7 early lock no credit" : "R6 lock interval", n, L_EXP);
    check("R9 done with release", int'(sdone), 1);
    check("R9 all released", rsts(), 0);
    @(negedge clk);
    check("R9 done single", int'(sdone), 0);
    lock = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 stays released", rsts(), 0);
    check("R10 no restart", int'(cfg_wr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", rsts(), 7);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 power-up hold", rsts(), 7);
    check("R1 no done", int'(sdone), 0);
    for (int m = 0; m < 8; m++) run_seq(m, m % 3, (m + 1) % 4, m % 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule